// File: doc/BRIEF.md
# SMBus Bus-State and Timeout Monitor

This block listens to the clock and data lines of a two-wire SMBus/I2C bus and keeps track of whether a transfer is in progress. Both lines pass through two-flop synchronizers. The block then looks for bus start and bus stop conditions. It runs two watchdogs. The first declares the bus free when both lines have been idle-high for long enough, counted in ticks of a selectable bit-rate source. The second flags a clock line that has been held low for too long.

An 8-bit configuration/status register holds the settings. It contains:
- an enable bit
- a slave-event inhibit
- the read-only busy flag
- an extended setup/hold flag, which is only exported for a neighbouring shifter
- two timeout enables
- a 2-bit choice among four external tick inputs

The block does not shift bytes, handle acknowledges, arbitrate or drive the lines. It carries no data stream, so every pin is a plain control or status signal with no handshake.

Top module: `smbus_bus_monitor`

## Requirements
- R1: After reset the register reads 0x00, and busy, the timeout pulse and the selected tick are all 0.
- R2: A write stores bit7 enable, bit6 slave inhibit, bit4 extended hold, bit3 clock-low timeout enable, bit2 free timeout enable and bits1:0 tick select. Bit5 always reads the busy flag, and writes to bit5 are ignored.
- R3: While enable is 0, busy reads 0, no timeout pulse is raised and the selected tick output is 0. Clearing enable drops busy, and busy stays 0 after enable is set again until a new start condition arrives.
- R4: Busy goes to 1 when the synchronized data line falls while the clock line is high. A data fall while the clock is low leaves busy at 0.
- R5: Busy goes to 0 when the synchronized data line rises while the clock line is high.
- R6: With free timeout enabled, busy clears once both lines have stayed high for more than FREE_TICKS (default 10) ticks of the selected source. Busy stays 1 after exactly FREE_TICKS ticks, and it also stays 1 when ticks arrive only on sources that are not selected. With free timeout disabled, the ticks never clear busy.
- R7: The selected tick output equals enable AND tick_src[sel], where select 0, 1, 2 and 3 pick tick_src bits 0, 1, 2 and 3.
- R8: With clock-low timeout enabled, a counter is held at zero while the clock line is high. After LOW_LIMIT cycles of continuous low it raises tmo_irq for exactly one cycle, once per low period, and it re-arms only after the clock returns high. A shorter low period raises nothing, and so does a disabled timeout.
- R9: evt_irq equals master_evt OR (slave_evt AND NOT inhibit).
- R10: ext_hold follows register bit4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read-back, with bit5 as busy |
| sda_in | input | 1 | Bus data line, asynchronous |
| scl_in | input | 1 | Bus clock line, asynchronous |
| tick_src | input | 4 | Four candidate bit-rate tick inputs |
| bit_tick | output | 1 | Selected tick, gated by enable |
| busy | output | 1 | Transfer in progress |
| ext_hold | output | 1 | Extended setup/hold setting |
| tmo_irq | output | 1 | One-cycle clock-low timeout pulse |
| slave_evt | input | 1 | Slave-mode interrupt request |
| master_evt | input | 1 | Master-mode interrupt request |
| evt_irq | output | 1 | Gated interrupt request |

## Verification
The hardest state to reach from the ports is a busy bus whose lines are both high with no stop condition ever having been seen. Only that state lets the free timeout be the thing that clears busy. The stimulus reaches it in four steps: issue a start, pull the clock low, release data while the clock is low, and then release the clock. The bench then counts ticks on the selected source up to and past the limit, and also plays ticks on a source that is not selected, so it can show that those are ignored.

// File: rtl/smb_mon_pkg.sv
`timescale 1ns/1ps
package smb_mon_pkg;
  localparam int CFG_W      = 8;
  localparam int B_EN       = 7;
  localparam int B_INH      = 6;
  localparam int B_BUSY     = 5;
  localparam int B_XHOLD    = 4;
  localparam int B_LOWTO    = 3;
  localparam int B_FREETO   = 2;
  localparam int SEL_W      = 2;
  localparam int NUM_TICKS  = 1 << SEL_W;
  localparam logic [CFG_W-1:0] BUSY_MASK = 8'h20;

  typedef struct packed {
    logic             en;
    logic             inh;
    logic             xhold;
    logic             low_to_en;
    logic             free_to_en;
    logic [SEL_W-1:0] sel;
  } mon_cfg_t;
endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_async,
  output logic [LINES-1:0] d_sync
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d_async[g]};
    end
    assign d_sync[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/smb_cond_detect.sv
`timescale 1ns/1ps
module smb_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sda,
  input  logic scl,
  output logic start_p,
  output logic stop_p,
  output logic both_high,
  output logic scl_low
);
  logic sda_d, scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_d <= 1'b1;
      scl_d <= 1'b1;
    end else begin
      sda_d <= sda;
      scl_d <= scl;
    end
  end

  // Clock must be high on both sides of the data edge.
  logic scl_steady_high;
  assign scl_steady_high = scl & scl_d;
  assign start_p   = en & scl_steady_high &  sda_d & ~sda;
  assign stop_p    = en & scl_steady_high & ~sda_d &  sda;
  assign both_high = sda & scl;
  assign scl_low   = ~scl;
endmodule

// File: rtl/smb_free_timer.sv
`timescale 1ns/1ps
module smb_free_timer #(
  parameter int FREE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic both_high,
  input  logic tick,
  output logic free_p
);
  localparam int CW = $clog2(FREE_TICKS + 1) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(FREE_TICKS);

  logic [CW-1:0] cnt;
  logic          free_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      free_q <= 1'b0;
    end else if (!run || !both_high) begin
      cnt    <= '0;
      free_q <= 1'b0;
    end else begin
      free_q <= 1'b0;
      if (tick) begin
        if (cnt == LIMIT) free_q <= 1'b1;   // tick number LIMIT+1
        else              cnt    <= cnt + 1'b1;
      end
    end
  end

  assign free_p = free_q;
endmodule

// File: rtl/smb_low_timer.sv
`timescale 1ns/1ps
module smb_low_timer #(
  parameter int LOW_LIMIT = 6250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic scl_low,
  output logic tmo_p
);
  localparam int LW = $clog2(LOW_LIMIT + 1) + 1;
  localparam logic [LW-1:0] LIMIT = LW'(LOW_LIMIT);
  localparam logic [LW-1:0] LAST  = LW'(LOW_LIMIT - 1);

  logic [LW-1:0] cnt;
  logic          tmo_q;
  logic          hold;

  assign hold = !run || !scl_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tmo_q <= 1'b0;
    end else begin
      tmo_q <= !hold && (cnt == LAST);
      if (hold)               cnt <= '0;
      else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
    end
  end

  assign tmo_p = tmo_q;
endmodule

// File: rtl/smbus_bus_monitor.sv
`timescale 1ns/1ps
module smbus_bus_monitor
  import smb_mon_pkg::*;
#(
  parameter int FREE_TICKS = 10,
  parameter int LOW_LIMIT  = 6250000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 sda_in,
  input  logic                 scl_in,
  input  logic [NUM_TICKS-1:0] tick_src,
  output logic                 bit_tick,
  output logic                 busy,
  output logic                 ext_hold,
  output logic                 tmo_irq,
  input  logic                 slave_evt,
  input  logic                 master_evt,
  output logic                 evt_irq
);
  logic [CFG_W-1:0] cfg_q;
  mon_cfg_t         cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata & ~BUSY_MASK;
  end

  assign cfg.en         = cfg_q[B_EN];
  assign cfg.inh        = cfg_q[B_INH];
  assign cfg.xhold      = cfg_q[B_XHOLD];
  assign cfg.low_to_en  = cfg_q[B_LOWTO];
  assign cfg.free_to_en = cfg_q[B_FREETO];
  assign cfg.sel        = cfg_q[SEL_W-1:0];

  // Line synchronizers
  logic [1:0] lines_s;
  logic       sda_s, scl_s;

  smb_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({scl_in, sda_in}),
    .d_sync (lines_s)
  );
  assign sda_s = lines_s[0];
  assign scl_s = lines_s[1];

  // Start / stop detection
  logic start_p, stop_p, both_high, scl_low;

  smb_cond_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.en),
    .sda      (sda_s),
    .scl      (scl_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .both_high(both_high),
    .scl_low  (scl_low)
  );

  // Tick selection
  logic sel_tick;
  assign sel_tick = tick_src[cfg.sel];
  assign bit_tick = cfg.en & sel_tick;

  // Idle-free timeout
  logic free_p;

  smb_free_timer #(.FREE_TICKS(FREE_TICKS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg.en & cfg.free_to_en),
    .both_high(both_high),
    .tick     (sel_tick),
    .free_p   (free_p)
  );

  // Clock-low timeout
  logic tmo_p;

  smb_low_timer #(.LOW_LIMIT(LOW_LIMIT)) u_low (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg.en & cfg.low_to_en),
    .scl_low(scl_low),
    .tmo_p  (tmo_p)
  );

  // Busy tracking
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_q <= 1'b0;
    else if (!cfg.en)          busy_q <= 1'b0;
    else if (start_p)          busy_q <= 1'b1;
    else if (stop_p || free_p) busy_q <= 1'b0;
  end

  assign busy     = busy_q & cfg.en;
  assign tmo_irq  = tmo_p & cfg.en;
  assign ext_hold = cfg.xhold;
  assign evt_irq  = master_evt | (slave_evt & ~cfg.inh);

  always_comb begin
    cfg_rdata         = cfg_q;
    cfg_rdata[B_BUSY] = busy;
  end
endmodule

// File: rtl/smbus_bus_monitor_chk.sv
`timescale 1ns/1ps
module smbus_bus_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_rdata,
  input logic       busy,
  input logic       tmo_irq,
  input logic       scl_s,
  input logic       start_p,
  input logic       stop_p,
  input logic       free_p,
  input logic       slave_evt,
  input logic       master_evt,
  input logic       evt_irq
);
  p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[7] |-> (!busy && !tmo_irq));

  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_p));

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!cfg_rdata[7] || $past(stop_p || free_p)));

  p_tmo_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |=> !tmo_irq);

  p_tmo_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_irq |-> $past(!scl_s));

  p_inh_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[6] && !master_evt) |-> !evt_irq);

  p_master_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |-> evt_irq);

  p_slave_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_evt && !cfg_rdata[6]) |-> evt_irq);
endmodule

bind smbus_bus_monitor smbus_bus_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .busy      (busy),
  .tmo_irq   (tmo_irq),
  .scl_s     (scl_s),
  .start_p   (start_p),
  .stop_p    (stop_p),
  .free_p    (free_p),
  .slave_evt (slave_evt),
  .master_evt(master_evt),
  .evt_irq   (evt_irq)
);

// File: tb/smbus_bus_monitor_tb.sv
`timescale 1ns/1ps
module smbus_bus_monitor_tb;
  localparam int FREE_T = 10;
  localparam int LOW_L  = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       sda_in = 1'b1;
  logic       scl_in = 1'b1;
  logic [3:0] tick_src = 4'h0;
  logic       bit_tick, busy, ext_hold, tmo_irq, evt_irq;
  logic       slave_evt = 1'b0;
  logic       master_evt = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [7:0] cfg_model = 8'h00;

  always #2 clk = ~clk;   // 250 MHz

  smbus_bus_monitor #(.FREE_TICKS(FREE_T), .LOW_LIMIT(LOW_L)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sda_in(sda_in), .scl_in(scl_in),
    .tick_src(tick_src), .bit_tick(bit_tick), .busy(busy),
    .ext_hold(ext_hold), .tmo_irq(tmo_irq), .slave_evt(slave_evt),
    .master_evt(master_evt), .evt_irq(evt_irq)
  );

  function automatic logic exp_tick(logic [7:0] c, logic [3:0] t);
    return c[7] & t[c[1:0]];
  endfunction

  function automatic logic exp_irq(logic [7:0] c, logic s, logic m);
    return m | (s & ~c[6]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    cfg_model = v & 8'hDF;
  endtask

  task automatic lines(input logic sda, input logic scl);
    sda_in = sda; scl_in = scl;
    cyc(5);
  endtask

  task automatic pulse_tick(input int idx);
    tick_src[idx] = 1'b1;
    cyc(1);
    tick_src[idx] = 1'b0;
    cyc(1);
  endtask

  // Counts tmo_irq cycles over n clocks while SCL is held low.
  task automatic low_window(input int n, output int cnt);
    cnt = 0;
    scl_in = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (tmo_irq) cnt++;
    end
    #1;
    scl_in = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (tmo_irq) cnt++;
    end
    #1;
  endtask

  // Start, then release data under a low clock: busy, both high, no stop.
  task automatic busy_idle_high();
    lines(1'b0, 1'b1);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired R1..all actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic [3:0] t;
    void'($urandom(32'h5EED_0017));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    @(negedge clk);
    // R1 reset
    chk(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(tmo_irq == 1'b0, "R1 tmo", tmo_irq, 0);
    chk(bit_tick == 1'b0, "R1 tick", bit_tick, 0);
    #1;

    // R2 / R10 register fields, bit5 ignored on write
    wr_cfg(8'h3F);
    @(negedge clk);
    chk(cfg_rdata == 8'h1F, "R2 readback busy bit ignored", cfg_rdata, 8'h1F);
    chk(ext_hold == 1'b1, "R10 ext_hold set", ext_hold, 1);
    #1;
    wr_cfg(8'h00);
    @(negedge clk);
    chk(ext_hold == 1'b0, "R10 ext_hold clear", ext_hold, 0);
    #1;

    // R3 disabled: start ignored, tick gated
    tick_src = 4'hF;
    lines(1'b0, 1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R3 busy while disabled", busy, 0);
    chk(bit_tick == 1'b0, "R3 tick while disabled", bit_tick, 0);
    #1;
    tick_src = 4'h0;
    lines(1'b1, 1'b1);

    // R7 random tick selection
    for (int i = 0; i < 200; i++) begin
      if (i % 20 == 0) wr_cfg(8'h80 | 8'($urandom_range(3)));
      t = 4'($urandom);
      tick_src = t;
      @(negedge clk);
      chk(bit_tick == exp_tick(cfg_model, t), "R7 tick select", bit_tick, exp_tick(cfg_model, t));
      #1;
    end
    tick_src = 4'h0;

    // R4 / R5 start and stop
    wr_cfg(8'h80);
    lines(1'b0, 1'b1);
    @(negedge clk);
    chk(busy == 1'b1, "R4 start sets busy", busy, 1);
    chk(cfg_rdata[5] == 1'b1, "R2 bit5 shows busy", cfg_rdata[5], 1);
    #1;
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 stop clears busy", busy, 0);
    #1;
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R4 data fall with clock low", busy, 0);
    #1;
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);

    // R3 disable drops busy, re-enable keeps 0
    lines(1'b0, 1'b1);
    wr_cfg(8'h00);
    @(negedge clk);
    chk(busy == 1'b0, "R3 disable clears busy", busy, 0);
    #1;
    wr_cfg(8'h80);
    cyc(3);
    @(negedge clk);
    chk(busy == 1'b0, "R3 re-enable no busy", busy, 0);
    #1;
    lines(1'b1, 1'b1);

    // R6 free timeout on source 2
    wr_cfg(8'h86);
    busy_idle_high();
    @(negedge clk);
    chk(busy == 1'b1, "R6 busy after idle-high setup", busy, 1);
    #1;
    for (int i = 0; i < 15; i++) pulse_tick(0);
    @(negedge clk);
    chk(busy == 1'b1, "R6 unselected ticks ignored", busy, 1);
    #1;
    for (int i = 0; i < FREE_T; i++) pulse_tick(2);
    @(negedge clk);
    chk(busy == 1'b1, "R6 exactly limit ticks", busy, 1);
    #1;
    pulse_tick(2);
    cyc(2);
    @(negedge clk);
    chk(busy == 1'b0, "R6 limit+1 ticks frees", busy, 0);
    #1;

    // R6 free timeout disabled
    wr_cfg(8'h82);
    busy_idle_high();
    for (int i = 0; i < 15; i++) pulse_tick(2);
    @(negedge clk);
    chk(busy == 1'b1, "R6 disabled never frees", busy, 1);
    #1;
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    @(negedge clk);
    chk(busy == 1'b0, "R5 stop after long idle", busy, 0);
    #1;

    // R8 clock-low timeout
    wr_cfg(8'h88);
    low_window(100, n);
    chk(n == 1, "R8 one pulse per low period", n, 1);
    low_window(100, n);
    chk(n == 1, "R8 re-arm after high", n, 1);
    low_window(20, n);
    chk(n == 0, "R8 short low no pulse", n, 0);
    wr_cfg(8'h80);
    low_window(100, n);
    chk(n == 0, "R8 disabled no pulse", n, 0);
    wr_cfg(8'h08);
    low_window(100, n);
    chk(n == 0, "R3 block off no pulse", n, 0);

    // R9 random inhibit / event gating
    for (int i = 0; i < 100; i++) begin
      if (i % 10 == 0) wr_cfg($urandom_range(1) ? 8'hC0 : 8'h80);
      slave_evt  = 1'($urandom);
      master_evt = 1'($urandom);
      @(negedge clk);
      chk(evt_irq == exp_irq(cfg_model, slave_evt, master_evt), "R9 irq gating",
          evt_irq, exp_irq(cfg_model, slave_evt, master_evt));
      #1;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule